// File: doc/BRIEF.md
# UART FIFO Trigger Control

This block holds the transmit and receive character queues of a UART and turns their fill state into service requests. A single 8-bit control write sets the queue mode, flushes either queue, picks the DMA signalling mode and chooses 2-bit threshold codes for each direction. Some of these fields are locked unless the divisor is idle or the enhanced-feature gate is open.

Each direction resolves its threshold in one of three ways. The first is a fixed coarse table indexed by the 2-bit code. The second is a nibble from a separate level register, scaled by four. The third is a fine 6-bit value whose upper four bits come from that nibble and whose lower two bits come from the code. The receive request rises when the number of stored characters reaches the receive threshold. The transmit request rises when the number of free slots reaches the transmit threshold. When DMA signalling is active, both requests are mirrored on a 2-bit DMA request output.

The serial shifter, baud generation, line status and bus decode sit outside this block. The shifter pops the transmit queue and pushes the receive queue. The host side does the reverse.

Top module: `uart_fifo_trig`

## Requirements
- R1: After reset, both counts are 0, `fifo_en` and `dma_mode` are 0, both read data outputs are 0, both overflow flags are 0 and both 2-bit threshold codes are 00.
- R2: Control bit 0 (queue enable) and bit 3 (DMA mode) take the written value only on a `ctl_wr` cycle with `div_zero` high. Otherwise `fifo_en` and `dma_mode` keep their values.
- R3: The transmit code (control bits 5:4) updates only on a `ctl_wr` cycle with `feat_en` high. The receive code (control bits 7:6) updates on every `ctl_wr`.
- R4: On a `ctl_wr` with `div_zero` high, bit 1 flushes the receive queue and bit 2 flushes the transmit queue. A flushed queue shows count 0 and a clear overflow flag from the next cycle. A write that changes the enable bit flushes both queues. Flush bits are not stored, and writing them as 0 changes nothing.
- R5: A queue holds up to 64 characters when `fifo_en` is 1 and one character when it is 0. A push into a full queue is dropped and sets that queue's sticky overflow flag, unless a pop in the same cycle frees a slot.
- R6: Characters leave in arrival order. Read data updates in the cycle after a pop. A pop from an empty queue leaves the read data and the count unchanged.
- R7: With fine mode off and `lvl_reg[7:4]` = 0, receive codes 00, 01, 10 and 11 give levels 8, 16, 56 and 60.
- R8: With fine mode off and `lvl_reg[3:0]` = 0, transmit codes 00, 01, 10 and 11 give levels 8, 16, 32 and 56.
- R9: With fine mode off and a nonzero nibble (`lvl_reg[7:4]` for receive, `lvl_reg[3:0]` for transmit), the level is four times the nibble and the code is ignored.
- R10: With fine mode on, the level is {nibble, code} as a 6-bit value. A result of 0 is raised to 1.
- R11: `rx_req` is high when `rx_count` is at least the effective receive level. `tx_req` is high when the free slots (capacity minus `tx_count`) are at least the effective transmit level. The effective level is the resolved level when `fifo_en` is 1 and 1 when it is 0.
- R12: `dma_req[0]` equals `tx_req` and `dma_req[1]` equals `rx_req` when `dma_mode` is 1 and `dma_alt` is 0. Otherwise `dma_req` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Control write data |
| feat_en | input | 1 | Enhanced-feature gate for the transmit code |
| div_zero | input | 1 | Both divisor bytes are zero (baud clock stopped) |
| lvl_reg | input | 8 | Level register: [7:4] receive nibble, [3:0] transmit nibble |
| rx_fine | input | 1 | Fine granularity for receive |
| tx_fine | input | 1 | Fine granularity for transmit |
| dma_alt | input | 1 | Alternate DMA select; when 1, DMA mode is ignored |
| tx_push | input | 1 | Host writes a transmit character |
| tx_wdata | input | 8 | Transmit character in |
| tx_pop | input | 1 | Shifter takes a transmit character |
| tx_rdata | output | 8 | Last transmit character taken |
| rx_push | input | 1 | Shifter delivers a received character |
| rx_wdata | input | 8 | Received character in |
| rx_pop | input | 1 | Host reads a received character |
| rx_rdata | output | 8 | Last received character read |
| tx_count | output | 7 | Transmit queue occupancy |
| rx_count | output | 7 | Receive queue occupancy |
| tx_ovf | output | 1 | Sticky transmit overflow |
| rx_ovf | output | 1 | Sticky receive overflow |
| fifo_en | output | 1 | Queue mode (1 = 64 deep) |
| dma_mode | output | 1 | Stored DMA mode bit |
| tx_level | output | 7 | Resolved transmit threshold |
| rx_level | output | 7 | Resolved receive threshold |
| tx_req | output | 1 | Transmit service request |
| rx_req | output | 1 | Receive service request |
| dma_req | output | 2 | DMA requests: [0] transmit, [1] receive |

## Verification
The assertions check these properties on every cycle:
- counts never exceed the current capacity;
- locked fields stay put without a divisor-idle write;
- a flush leaves an empty queue with a clear flag;
- a push into a full queue sets the overflow flag;
- a pop from an empty queue keeps the read data;
- the DMA outputs stay quiet when gated;
- resolved levels stay in the range 1 to 63.

Only the bench scenarios show the exact values of the coarse tables, nibble scaling and fine packing, as well as the arrival order of characters, the transmit-code lock and the exact cycle in which each request crosses its threshold. A behavioural queue model checks all of these on every clock.

// File: rtl/uft_pkg.sv
package uft_pkg;
    localparam int DATA_W     = 8;
    localparam int FIFO_DEPTH = 64;
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);

    // control word field positions decoded by this block
    localparam int BIT_EN    = 0;
    localparam int BIT_RXCLR = 1;
    localparam int BIT_TXCLR = 2;
    localparam int BIT_DMA   = 3;
    localparam int TXC_LO    = 4;
    localparam int RXC_LO    = 6;

    typedef struct packed {
        logic       en;
        logic       dma;
        logic [1:0] tx_code;
        logic [1:0] rx_code;
    } ctl_t;
endpackage

// File: rtl/uft_fifo.sv
module uft_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              single,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  count,
    output logic              overflow
);
    typedef struct packed {
        logic [PTR_W-1:0]  wp;
        logic [PTR_W-1:0]  rp;
        logic [CNT_W-1:0]  cnt;
        logic              ovf;
        logic [DATA_W-1:0] rd;
    } st_t;

    st_t s_q, s_d;
    logic [DATA_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]  cap;
    logic              pop_ok;
    logic              push_ok;

    always_comb begin
        s_d     = s_q;
        cap     = single ? CNT_W'(1) : CNT_W'(DEPTH);
        pop_ok  = pop && (s_q.cnt != '0) && !flush;
        push_ok = push && ((s_q.cnt < cap) || pop_ok) && !flush;
        if (flush) begin
            s_d.wp  = '0;
            s_d.rp  = '0;
            s_d.cnt = '0;
            s_d.ovf = 1'b0;
        end else begin
            if (pop_ok) begin
                s_d.rd = mem[s_q.rp];
                s_d.rp = s_q.rp + PTR_W'(1);
            end
            if (push_ok) begin
                s_d.wp = s_q.wp + PTR_W'(1);
            end
            if (push && !push_ok) begin
                s_d.ovf = 1'b1;
            end
            s_d.cnt = s_q.cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[s_q.wp] <= wdata;
        end
    end

    assign rdata    = s_q.rd;
    assign count    = s_q.cnt;
    assign overflow = s_q.ovf;
endmodule

// File: rtl/uft_thresh.sv
module uft_thresh #(
    parameter bit RX_SIDE = 1'b1,
    parameter int CNT_W   = 7
) (
    input  logic [1:0]       code,
    input  logic [3:0]       nib,
    input  logic             fine,
    output logic [CNT_W-1:0] level
);
    logic [CNT_W-1:0] coarse;
    logic [5:0]       fine_val;

    if (RX_SIDE) begin : g_rx_table
        always_comb begin
            case (code)
                2'd0:    coarse = CNT_W'(8);
                2'd1:    coarse = CNT_W'(16);
                2'd2:    coarse = CNT_W'(56);
                default: coarse = CNT_W'(60);
            endcase
        end
    end else begin : g_tx_table
        always_comb begin
            case (code)
                2'd0:    coarse = CNT_W'(8);
                2'd1:    coarse = CNT_W'(16);
                2'd2:    coarse = CNT_W'(32);
                default: coarse = CNT_W'(56);
            endcase
        end
    end

    always_comb begin
        fine_val = {nib, code};
        if (fine) begin
            level = (fine_val == 6'd0) ? CNT_W'(1) : CNT_W'(fine_val);
        end else if (nib != 4'd0) begin
            level = CNT_W'({nib, 2'b00});
        end else begin
            level = coarse;
        end
    end
endmodule

// File: rtl/uart_fifo_trig.sv
module uart_fifo_trig
    import uft_pkg::*;
#(
    parameter int DW    = uft_pkg::DATA_W,
    parameter int DEPTH = uft_pkg::FIFO_DEPTH,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic [7:0]    ctl_wdata,
    input  logic          feat_en,
    input  logic          div_zero,
    input  logic [7:0]    lvl_reg,
    input  logic          rx_fine,
    input  logic          tx_fine,
    input  logic          dma_alt,
    input  logic          tx_push,
    input  logic [DW-1:0] tx_wdata,
    input  logic          tx_pop,
    output logic [DW-1:0] tx_rdata,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_wdata,
    input  logic          rx_pop,
    output logic [DW-1:0] rx_rdata,
    output logic [CW-1:0] tx_count,
    output logic [CW-1:0] rx_count,
    output logic          tx_ovf,
    output logic          rx_ovf,
    output logic          fifo_en,
    output logic          dma_mode,
    output logic [CW-1:0] tx_level,
    output logic [CW-1:0] rx_level,
    output logic          tx_req,
    output logic          rx_req,
    output logic [1:0]    dma_req
);
    ctl_t    ctl_q, ctl_d;
    logic    wr_gated;
    logic    en_flip;
    logic    flush_tx;
    logic    flush_rx;
    logic [CW-1:0] cap;
    logic [CW-1:0] tx_free;
    logic [CW-1:0] tx_eff;
    logic [CW-1:0] rx_eff;

    always_comb begin
        ctl_d    = ctl_q;
        wr_gated = ctl_wr && div_zero;
        en_flip  = wr_gated && (ctl_wdata[BIT_EN] != ctl_q.en);
        flush_rx = (wr_gated && ctl_wdata[BIT_RXCLR]) || en_flip;
        flush_tx = (wr_gated && ctl_wdata[BIT_TXCLR]) || en_flip;
        if (wr_gated) begin
            ctl_d.en  = ctl_wdata[BIT_EN];
            ctl_d.dma = ctl_wdata[BIT_DMA];
        end
        if (ctl_wr && feat_en) begin
            ctl_d.tx_code = ctl_wdata[TXC_LO +: 2];
        end
        if (ctl_wr) begin
            ctl_d.rx_code = ctl_wdata[RXC_LO +: 2];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    uft_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u_tx_q (
        .clk(clk), .rst_n(rst_n), .flush(flush_tx), .single(!ctl_q.en),
        .push(tx_push), .wdata(tx_wdata), .pop(tx_pop),
        .rdata(tx_rdata), .count(tx_count), .overflow(tx_ovf)
    );

    uft_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u_rx_q (
        .clk(clk), .rst_n(rst_n), .flush(flush_rx), .single(!ctl_q.en),
        .push(rx_push), .wdata(rx_wdata), .pop(rx_pop),
        .rdata(rx_rdata), .count(rx_count), .overflow(rx_ovf)
    );

    uft_thresh #(.RX_SIDE(1'b0), .CNT_W(CW)) u_tx_lvl (
        .code(ctl_q.tx_code), .nib(lvl_reg[3:0]), .fine(tx_fine), .level(tx_level)
    );

    uft_thresh #(.RX_SIDE(1'b1), .CNT_W(CW)) u_rx_lvl (
        .code(ctl_q.rx_code), .nib(lvl_reg[7:4]), .fine(rx_fine), .level(rx_level)
    );

    always_comb begin
        cap     = ctl_q.en ? CW'(DEPTH) : CW'(1);
        tx_free = cap - tx_count;
        tx_eff  = ctl_q.en ? tx_level : CW'(1);
        rx_eff  = ctl_q.en ? rx_level : CW'(1);
        tx_req  = tx_free >= tx_eff;
        rx_req  = rx_count >= rx_eff;
        dma_req = (ctl_q.dma && !dma_alt) ? {rx_req, tx_req} : 2'b00;
    end

    assign fifo_en  = ctl_q.en;
    assign dma_mode = ctl_q.dma;
endmodule

// File: rtl/uft_checker.sv
module uft_checker #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctl_wr,
    input logic [7:0]    ctl_wdata,
    input logic          div_zero,
    input logic          dma_alt,
    input logic          tx_push,
    input logic          tx_pop,
    input logic [DW-1:0] tx_rdata,
    input logic          rx_push,
    input logic          rx_pop,
    input logic [DW-1:0] rx_rdata,
    input logic [CW-1:0] tx_count,
    input logic [CW-1:0] rx_count,
    input logic          tx_ovf,
    input logic          rx_ovf,
    input logic          fifo_en,
    input logic          dma_mode,
    input logic [CW-1:0] tx_level,
    input logic [CW-1:0] rx_level,
    input logic          tx_req,
    input logic          rx_req,
    input logic [1:0]    dma_req
);
    logic [CW-1:0] cap;
    assign cap = fifo_en ? CW'(DEPTH) : CW'(1);

    p_cap_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count <= cap) && (tx_count <= cap));

    p_locked_cfg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_wr && div_zero) |=> ($stable(fifo_en) && $stable(dma_mode)));

    p_flush_rx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && div_zero && ctl_wdata[1]) |=> (rx_count == '0 && !rx_ovf));

    p_flush_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && div_zero && ctl_wdata[2]) |=> (tx_count == '0 && !tx_ovf));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !rx_pop && rx_count == cap && !(ctl_wr && div_zero)) |=> rx_ovf);

    p_empty_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop && tx_count == '0) |=> $stable(tx_rdata));

    p_empty_pop_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && rx_count == '0) |=> $stable(rx_rdata));

    p_dma_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_alt || !dma_mode) |-> (dma_req == 2'b00));

    p_level_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level != '0) && (rx_level <= CW'(63)) && (tx_level != '0) && (tx_level <= CW'(63)));

    p_req_edges_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0 |-> !rx_req) and (tx_count == '0 |-> tx_req));
endmodule

bind uart_fifo_trig uft_checker #(.DW(DW), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_uart_fifo_trig.sv
`timescale 1ns/1ps
module tb_uart_fifo_trig;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       feat_en = 1'b0;
    logic       div_zero = 1'b0;
    logic [7:0] lvl_reg = '0;
    logic       rx_fine = 1'b0;
    logic       tx_fine = 1'b0;
    logic       dma_alt = 1'b0;
    logic       tx_push = 1'b0;
    logic [7:0] tx_wdata = '0;
    logic       tx_pop = 1'b0;
    logic [7:0] tx_rdata;
    logic       rx_push = 1'b0;
    logic [7:0] rx_wdata = '0;
    logic       rx_pop = 1'b0;
    logic [7:0] rx_rdata;
    logic [6:0] tx_count, rx_count, tx_level, rx_level;
    logic       tx_ovf, rx_ovf, fifo_en, dma_mode, tx_req, rx_req;
    logic [1:0] dma_req;

    always #2 clk = ~clk;

    uart_fifo_trig dut (.*);

    int n_chk = 0;
    int n_bad = 0;

    // behavioural reference state
    logic [7:0] mtx[$];
    logic [7:0] mrx[$];
    bit         m_en, m_dma, m_txovf, m_rxovf;
    bit [1:0]   m_txc, m_rxc;
    logic [7:0] m_txrd, m_rxrd;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int lvl_of(input bit rx, input bit [1:0] code, input bit [3:0] nib, input bit fine);
        int v;
        if (fine) begin
            v = nib * 4 + code;
            return (v == 0) ? 1 : v;
        end
        if (nib != 0) return nib * 4;
        if (rx) return (code == 0) ? 8 : (code == 1) ? 16 : (code == 2) ? 56 : 60;
        return (code == 0) ? 8 : (code == 1) ? 16 : (code == 2) ? 32 : 56;
    endfunction

    function automatic string lvl_tag(input bit rx, input bit [3:0] nib, input bit fine);
        if (fine) return "R10";
        if (nib != 0) return "R9";
        return rx ? "R7" : "R8";
    endfunction

    task automatic mstep(ref logic [7:0] q[$], ref bit ovf, ref logic [7:0] rd,
                         input bit fl, input bit pu, input bit po, input logic [7:0] d, input int cap);
        bit pop_ok;
        if (fl) begin
            q.delete();
            ovf = 1'b0;
        end else begin
            pop_ok = po && (q.size() > 0);
            if (pop_ok) rd = q.pop_front();
            if (pu) begin
                if (q.size() < cap) q.push_back(d);
                else ovf = 1'b1;
            end
        end
    endtask

    always @(posedge clk) begin
        bit wg, flip, frx, ftx;
        int cap;
        if (!rst_n) begin
            mtx.delete(); mrx.delete();
            m_en = 0; m_dma = 0; m_txovf = 0; m_rxovf = 0;
            m_txc = 0; m_rxc = 0; m_txrd = 0; m_rxrd = 0;
        end else begin
            cap  = m_en ? 64 : 1;
            wg   = ctl_wr && div_zero;
            flip = wg && (ctl_wdata[0] != m_en);
            frx  = (wg && ctl_wdata[1]) || flip;
            ftx  = (wg && ctl_wdata[2]) || flip;
            mstep(mtx, m_txovf, m_txrd, ftx, tx_push, tx_pop, tx_wdata, cap);
            mstep(mrx, m_rxovf, m_rxrd, frx, rx_push, rx_pop, rx_wdata, cap);
            if (wg) begin m_en = ctl_wdata[0]; m_dma = ctl_wdata[3]; end
            if (ctl_wr && feat_en) m_txc = ctl_wdata[5:4];
            if (ctl_wr) m_rxc = ctl_wdata[7:6];
        end
    end

    task automatic compare_all();
        int txl, rxl, txe, rxe, cap, free;
        bit etx, erx;
        logic [1:0] edma;
        txl  = lvl_of(0, m_txc, lvl_reg[3:0], tx_fine);
        rxl  = lvl_of(1, m_rxc, lvl_reg[7:4], rx_fine);
        cap  = m_en ? 64 : 1;
        free = cap - mtx.size();
        txe  = m_en ? txl : 1;
        rxe  = m_en ? rxl : 1;
        etx  = free >= txe;
        erx  = mrx.size() >= rxe;
        edma = (m_dma && !dma_alt) ? {erx, etx} : 2'b00;
        chk(fifo_en == m_en, "R2 fifo_en", fifo_en, m_en);
        chk(dma_mode == m_dma, "R2 dma_mode", dma_mode, m_dma);
        chk(tx_level == txl, lvl_tag(0, lvl_reg[3:0], tx_fine), tx_level, txl);
        chk(rx_level == rxl, lvl_tag(1, lvl_reg[7:4], rx_fine), rx_level, rxl);
        chk(tx_count == mtx.size(), "R5 tx_count", tx_count, mtx.size());
        chk(rx_count == mrx.size(), "R5 rx_count", rx_count, mrx.size());
        chk(tx_ovf == m_txovf, "R5 tx_ovf", tx_ovf, m_txovf);
        chk(rx_ovf == m_rxovf, "R5 rx_ovf", rx_ovf, m_rxovf);
        chk(tx_rdata == m_txrd, "R6 tx_rdata", tx_rdata, m_txrd);
        chk(rx_rdata == m_rxrd, "R6 rx_rdata", rx_rdata, m_rxrd);
        chk(tx_req == etx, "R11 tx_req", tx_req, etx);
        chk(rx_req == erx, "R11 rx_req", rx_req, erx);
        chk(dma_req == edma, "R12 dma_req", dma_req, edma);
    endtask

    // one clock: inputs already set after a falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr_ctl(input logic [7:0] d);
        ctl_wr = 1'b1; ctl_wdata = d;
        tick();
        ctl_wr = 1'b0;
    endtask

    task automatic step(input bit tpu, input bit tpo, input bit rpu, input bit rpo);
        tx_push = tpu; tx_pop = tpo; rx_push = rpu; rx_pop = rpo;
        tx_wdata = 8'($urandom); rx_wdata = 8'($urandom);
        tick();
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(tx_count == 0 && rx_count == 0, "R1 counts", rx_count, 0);
        chk(!fifo_en && !dma_mode, "R1 mode bits", {fifo_en, dma_mode}, 0);
        chk(tx_rdata == 0 && rx_rdata == 0 && !tx_ovf && !rx_ovf, "R1 data/flags", rx_rdata, 0);
        chk(rx_level == 8 && tx_level == 8, "R1 codes 00", rx_level, 8);
        compare_all();

        // R2/R3: divisor running, enable and DMA locked; rx code still taken
        div_zero = 0; feat_en = 0;
        wr_ctl(8'hF9);
        chk(fifo_en == 0, "R2 locked enable", fifo_en, 0);
        chk(rx_level == 60 && tx_level == 8, "R3 rx code open tx code locked", rx_level, 60);

        // R2/R3: divisor idle, feature gate closed
        div_zero = 1;
        wr_ctl(8'h39);
        chk(fifo_en == 1 && dma_mode == 1, "R2 enable taken", fifo_en, 1);
        chk(tx_level == 8, "R3 tx code locked", tx_level, 8);
        feat_en = 1;
        for (int c = 0; c < 4; c++) begin
            wr_ctl(8'((c << 6) | (c << 4) | 9));
            chk(tx_level == lvl_of(0, 2'(c), 0, 0), "R8 coarse tx", tx_level, lvl_of(0, 2'(c), 0, 0));
            chk(rx_level == lvl_of(1, 2'(c), 0, 0), "R7 coarse rx", rx_level, lvl_of(1, 2'(c), 0, 0));
        end
        wr_ctl(8'h09); // codes 00, enabled, dma

        // R5 fill receive past full, R6 drain order
        for (int i = 0; i < 66; i++) step(0, 0, 1, 0);
        chk(rx_ovf == 1 && rx_count == 64, "R5 overflow on full", rx_count, 64);
        step(0, 1, 1, 1);
        chk(rx_count == 64, "R5 push with pop on full", rx_count, 64);
        for (int i = 0; i < 66; i++) step(0, 0, 0, 1);
        chk(rx_count == 0, "R6 drained", rx_count, 0);

        // transmit occupancy against levels
        for (int i = 0; i < 50; i++) step(1, 0, 0, 0);
        wr_ctl(8'h29); // tx code 10 -> 32
        for (int i = 0; i < 20; i++) step(0, 1, 0, 0);

        // R4 flush receive only, zeros do nothing
        for (int i = 0; i < 10; i++) step(1, 0, 1, 0);
        wr_ctl(8'h09);
        chk(rx_count == 10, "R4 zero flush bits", rx_count, 10);
        wr_ctl(8'h0B);
        chk(rx_count == 0 && tx_count != 0, "R4 rx flush only", rx_count, 0);
        div_zero = 0;
        wr_ctl(8'h0D);
        chk(tx_count != 0, "R4 flush locked", tx_count, 1);
        div_zero = 1;
        wr_ctl(8'h0D);
        chk(tx_count == 0, "R4 tx flush", tx_count, 0);

        // R9 nibble mode and R10 fine mode
        for (int i = 0; i < 30; i++) step(0, 0, 1, 0);
        lvl_reg = 8'h73; tick();
        chk(rx_level == 28 && tx_level == 12, "R9 nibble scaling", rx_level, 28);
        rx_fine = 1; tx_fine = 1; wr_ctl(8'hD9);
        chk(rx_level == 31 && tx_level == 13, "R10 fine packing", rx_level, 31);
        lvl_reg = 8'h00; wr_ctl(8'h09);
        chk(rx_level == 1 && tx_level == 1, "R10 zero raised to 1", rx_level, 1);
        lvl_reg = 8'hF0; wr_ctl(8'hC9);
        chk(rx_level == 63, "R10 top value", rx_level, 63);

        // R12 alternate DMA select
        dma_alt = 1; tick();
        chk(dma_req == 0, "R12 gated by alt", dma_req, 0);
        dma_alt = 0; tick();
        rx_fine = 0; tx_fine = 0; lvl_reg = 0; tick();

        // R5 single entry mode after disable
        wr_ctl(8'h00);
        chk(rx_count == 0 && fifo_en == 0, "R4 enable change flushes", rx_count, 0);
        step(1, 0, 1, 0); step(1, 0, 1, 0);
        chk(rx_ovf == 1 && rx_count == 1, "R5 single entry", rx_count, 1);
        step(1, 1, 1, 1);
        step(0, 1, 0, 1); step(0, 1, 0, 1);
        chk(rx_count == 0, "R6 empty pop", rx_count, 0);

        // mixed traffic with occasional control writes
        wr_ctl(8'h09);
        for (int i = 0; i < 400; i++) begin
            if (($urandom % 40) == 0) begin
                ctl_wr = 1; ctl_wdata = 8'($urandom) | 8'h01;
                div_zero = 1'($urandom); feat_en = 1'($urandom);
            end
            if (($urandom % 25) == 0) begin
                lvl_reg = 8'($urandom); rx_fine = 1'($urandom); tx_fine = 1'($urandom);
                dma_alt = 1'($urandom);
            end
            step(($urandom % 3) != 0, ($urandom % 2) == 0, ($urandom % 3) != 0, ($urandom % 2) == 0);
            ctl_wr = 0;
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule